// File: doc/BRIEF.md
# SM3 Message Expansion, Second Stage

This block finishes four words of the SM3 message schedule in a single step. It takes three 128-bit operands, each split into four 32-bit lanes. The first holds the partial results from the first expansion step. The second holds history words W3..W6. The third holds history words W10..W13. It produces the new schedule words W16..W19.

Each lane combines a rotated early history word, a later history word and the matching partial result with XOR. W19 also depends on W16, which is computed in the same group. The block handles this by feeding the lane-0 result, without a register, into extra rotate-and-XOR logic on lane 3. The result passes through one register stage. A valid flag travels alongside the data, and a synchronous active-high reset clears that flag.

Top module: `sm3_msg2_stage`

## Requirements
- R1: Lane i of an operand is bits [32i+31:32i]. In `tmp_i`, lane i carries partial word T(i). In `hist_lo_i`, lane i carries W(3+i). In `hist_hi_i`, lane i carries W(10+i), for i = 0..3.
- R2: For lanes 0, 1 and 2, the output word W(16+i) equals rotl(W(3+i),7) XOR W(10+i) XOR T(i). Here rotl is a 32-bit left rotation with the count taken modulo 32.
- R3: The lane-3 output W19 equals rotl(W6,7) XOR W13 XOR T(3) XOR rotl(W16,6) XOR rotl(W16,15) XOR rotl(W16,30). W16 is the lane-0 result of the same operation.
- R4: `w_next_o` lane i (bits [32i+31:32i]) holds W(16+i).
- R5: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `w_next_o` holds the result for the inputs sampled at that edge. When `in_valid` is low, `out_valid` is low after that edge.
- R6: While `rst` is high at a rising edge, `out_valid` is low after that edge, even with `in_valid` high.
- R7: When `in_valid` is low at an edge, `w_next_o` keeps its previous value, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid this cycle |
| tmp_i | input | 128 | Partial words T0..T3 from the first step |
| hist_lo_i | input | 128 | History words W3..W6 |
| hist_hi_i | input | 128 | History words W10..W13 |
| out_valid | output | 1 | Result is valid |
| w_next_o | output | 128 | New words W16..W19 |

## Verification
The hardest case to reach is a fault in the lane-3 fold. It is only seen when W16 is nonzero, and it can be hidden when lane 0 and lane 3 inputs happen to cancel each other. The stimulus therefore walks a single set bit through every position of all three operands. A single bit in lane 0 makes W16 a one-bit value, and each of the three fold rotations then shows up as its own distinct bit in W19. Pseudo-random operands streamed back to back follow the walk and exercise full-width mixing at one result per cycle.

// File: rtl/sm3_msg2_pkg.sv
package sm3_msg2_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned N_LANES = 4;
    localparam int unsigned BUS_W   = WORD_W * N_LANES;

    // rotation amounts of the second expansion step
    localparam int unsigned ROT_HIST = 7;
    localparam int unsigned ROT_F0   = 6;
    localparam int unsigned ROT_F1   = 15;
    localparam int unsigned ROT_F2   = 30;
    localparam int unsigned FOLD_LANE = N_LANES - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [N_LANES-1:0] quad_t;

    typedef struct packed {
        quad_t tmp;
        quad_t hist_lo;
        quad_t hist_hi;
    } msg2_req_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        int unsigned k;
        k = n % WORD_W;
        if (k == 0) return x;
        return (x << k) | (x >> (WORD_W - k));
    endfunction

endpackage

// File: rtl/sm3_msg2_lane.sv
module sm3_msg2_lane
    import sm3_msg2_pkg::*;
(
    input  word_t tmp_w,
    input  word_t early_w,
    input  word_t late_w,
    output word_t base_w
);
    always_comb begin
        base_w = rotl(early_w, ROT_HIST) ^ late_w ^ tmp_w;
    end
endmodule

// File: rtl/sm3_msg2_fold.sv
module sm3_msg2_fold
    import sm3_msg2_pkg::*;
(
    input  word_t lead_w,
    input  word_t base_w,
    output word_t fixed_w
);
    word_t mix_w;
    always_comb begin
        mix_w   = rotl(lead_w, ROT_F0) ^ rotl(lead_w, ROT_F1) ^ rotl(lead_w, ROT_F2);
        fixed_w = base_w ^ mix_w;
    end
endmodule

// File: rtl/sm3_msg2_stage.sv
module sm3_msg2_stage
    import sm3_msg2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] tmp_i,
    input  logic [BUS_W-1:0] hist_lo_i,
    input  logic [BUS_W-1:0] hist_hi_i,
    output logic             out_valid,
    output logic [BUS_W-1:0] w_next_o
);
    msg2_req_t req;
    quad_t     base_q;
    quad_t     next_q;
    quad_t     out_q;
    logic      vld_q;

    assign req.tmp     = quad_t'(tmp_i);
    assign req.hist_lo = quad_t'(hist_lo_i);
    assign req.hist_hi = quad_t'(hist_hi_i);

    // R1, R2: one independent XOR lane per word
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        sm3_msg2_lane u_lane (
            .tmp_w   (req.tmp[g]),
            .early_w (req.hist_lo[g]),
            .late_w  (req.hist_hi[g]),
            .base_w  (base_q[g])
        );
        if (g != FOLD_LANE) begin : g_pass
            assign next_q[g] = base_q[g];
        end
    end

    // R3: lane 0 feeds the last lane before the register
    sm3_msg2_fold u_fold (
        .lead_w  (base_q[0]),
        .base_w  (base_q[FOLD_LANE]),
        .fixed_w (next_q[FOLD_LANE])
    );

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end

    always_ff @(posedge clk) begin
        if (in_valid) out_q <= next_q;
    end

    assign out_valid = vld_q;
    assign w_next_o  = BUS_W'(out_q);

    p_valid_up_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_dn_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_r6: assert property (@(posedge clk)
        rst |=> !out_valid);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(w_next_o));
    p_lane0_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> w_next_o[WORD_W-1:0] ==
            $past(rotl(hist_lo_i[WORD_W-1:0], 7) ^ hist_hi_i[WORD_W-1:0] ^ tmp_i[WORD_W-1:0]));
    p_lane3_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (w_next_o[BUS_W-1 -: WORD_W]
                      ^ rotl(w_next_o[WORD_W-1:0], 6)
                      ^ rotl(w_next_o[WORD_W-1:0], 15)
                      ^ rotl(w_next_o[WORD_W-1:0], 30)) ==
            $past(rotl(hist_lo_i[BUS_W-1 -: WORD_W], 7) ^ hist_hi_i[BUS_W-1 -: WORD_W]
                  ^ tmp_i[BUS_W-1 -: WORD_W]));
endmodule

// File: tb/sm3_msg2_stage_tb_top.sv
`timescale 1ns/1ps
module sm3_msg2_stage_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] tmp_i, hist_lo_i, hist_hi_i;
    logic         out_valid;
    logic [127:0] w_next_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    sm3_msg2_stage dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .tmp_i(tmp_i), .hist_lo_i(hist_lo_i), .hist_hi_i(hist_hi_i),
        .out_valid(out_valid), .w_next_o(w_next_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        logic [63:0] d;
        d = {x, x} << (n % 32);
        return d[63:32];
    endfunction

    function automatic logic [127:0] model(input logic [127:0] t,
                                           input logic [127:0] lo,
                                           input logic [127:0] hi);
        logic [31:0] w [4];
        for (int i = 0; i < 4; i++)
            w[i] = rl(lo[32*i +: 32], 7) ^ hi[32*i +: 32] ^ t[32*i +: 32];
        w[3] = w[3] ^ rl(w[0], 6) ^ rl(w[0], 15) ^ rl(w[0], 30);
        return {w[3], w[2], w[1], w[0]};
    endfunction

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the following posedge
    task automatic apply(input logic [127:0] t, input logic [127:0] lo,
                         input logic [127:0] hi);
        logic [127:0] e;
        @(negedge clk);
        tmp_i = t; hist_lo_i = lo; hist_hi_i = hi; in_valid = 1'b1;
        e = model(t, lo, hi);
        @(posedge clk); #1;
        check("R5 valid", {127'b0, out_valid}, 128'd1);
        // R1 R4 lane placement, R2 lanes 0..2
        check("R2", {32'b0, w_next_o[95:0]}, {32'b0, e[95:0]});
        check("R3", {96'b0, w_next_o[127:96]}, {96'b0, e[127:96]});
    endtask

    initial begin
        logic [127:0] lf;
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0;
        tmp_i = '0; hist_lo_i = '0; hist_hi_i = '0;
        repeat (2) @(posedge clk);
        #1 check("R6 reset state", {127'b0, out_valid}, 128'd0);
        @(negedge clk); rst = 1'b0;

        apply('0, '0, '0);
        apply('1, '1, '1);
        // walking single bit through every operand position
        for (int op = 0; op < 3; op++) begin
            for (int b = 0; b < 128; b++) begin
                logic [127:0] v;
                v = 128'd1 << b;
                apply(op == 0 ? v : '0, op == 1 ? v : '0, op == 2 ? v : '0);
            end
        end
        // pseudo-random streaming, one result per cycle
        lf = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
        for (int k = 0; k < 200; k++) begin
            logic [127:0] a, b2, c;
            lf = {lf[126:0], lf[127] ^ lf[125] ^ lf[100] ^ lf[98]};
            a = lf;
            b2 = {lf[63:0], lf[127:64]} ^ 128'h5a5a;
            c = ~{lf[31:0], lf[127:32]};
            apply(a, b2, c);
        end

        // R7: inputs change with in_valid low, output must hold
        held = w_next_o;
        @(negedge clk);
        in_valid = 1'b0; tmp_i = '1; hist_lo_i = 128'h1234; hist_hi_i = '0;
        @(posedge clk); #1;
        check("R5 valid low", {127'b0, out_valid}, 128'd0);
        check("R7 hold", w_next_o, held);
        @(posedge clk); #1;
        check("R7 hold again", w_next_o, held);

        // R6: reset wins over in_valid
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        check("R6 reset with valid", {127'b0, out_valid}, 128'd0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        apply(128'h1, 128'h0, 128'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule